// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to sixteen interrupt sources into one interrupt line to a CPU. Each source is an asynchronous signal. A rising edge on a source passes through a synchroniser and an edge detector, then sets a sticky request bit. A per-source enable mask gates each request. The OR of the gated requests drives the CPU interrupt line.

Software controls the block with write strobes to four write registers. One clears selected requests. One clears selected enable bits. One sets selected enable bits. One loads an 8-bit vector for a chosen source. A 32-bit status word shows the gated requests and the raw requests side by side.

When the CPU raises its acknowledge line, the controller picks the lowest-numbered gated request and latches it. While the acknowledge stays high, the controller drives that source's vector. It clears only that one request, so any other pending sources raise the line again for the next acknowledge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A request bit is set only by a rising edge of its source. The edge reaches the request register SYNC_STAGES+1 clock edges after the source is first sampled high. A source held high does not set its request again after the request is cleared.
- R2: A write with `bus_sel_i` = 0 clears every request bit whose position in `bus_wdata_i` holds 1. Bits written as 0 keep their value.
- R3: A write with `bus_sel_i` = 1 clears the enable bits at the positions written as 1. A write with `bus_sel_i` = 2 sets them. Other enable bits are unchanged.
- R4: After reset, all requests, all enable bits and all vectors are 0, and `irq_o` is low.
- R5: Writes to the enable mask never change the request bits. A request captured while masked raises `irq_o` as soon as its enable bit is set.
- R6: `irq_o` is high exactly when some request bit and its enable bit are both 1.
- R7: A write with `bus_sel_i` = 3 stores `bus_wdata_i[7:0]` as the vector of the source whose index is in `bus_wdata_i[11:8]`.
- R8: When several gated requests are pending, the source with the lowest index wins the acknowledge.
- R9: On the clock edge where `ack_i` is first seen high, the block latches the winner and clears only the winner's request bit. From the next cycle until `ack_i` falls, `vec_o` carries the winner's vector. At all other times `vec_o` is 0. An acknowledge with no gated request pending drives 0 and clears nothing.
- R10: `status_o[15:0]` holds the requests ANDed with the enable mask. `status_o[31:16]` holds the raw requests.
- R11: The vector driven during one acknowledge does not change, even if new edges arrive or vectors are rewritten while `ack_i` is high.
- R12: If a captured edge and a clear (from a write or an acknowledge) hit the same request bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Asynchronous interrupt sources |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_sel_i | input | 2 | Write register select: 0 clear, 1 disable, 2 enable, 3 vector |
| bus_wdata_i | input | WDATA_W | Write data |
| ack_i | input | 1 | Interrupt acknowledge from the CPU |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | VEC_W | Vector driven during acknowledge, 0 otherwise |
| status_o | output | 2*NUM_SRC | {raw requests, gated requests} |

## Verification
The bench builds the block with sixteen sources, 8-bit vectors, a 16-bit write bus and a two-stage synchroniser. These are the defaults. With these values the status word fills exactly 32 bits, and the index field fills exactly four bits, so every source index and every vector value can be reached. Because the synchroniser depth is known, the bench can line up a source edge with a clear write on the same cycle. The bench also makes new edges arrive while an acknowledge is held, and checks that the vector and the cleared bit stay tied to the winner chosen at the start.

// File: rtl/vic_pkg.sv
package vic_pkg;

   // Write register select codes
   typedef enum logic [1:0] {
      SEL_CLR = 2'd0,   // clear requests (write ones)
      SEL_DIS = 2'd1,   // clear enable bits (write ones)
      SEL_ENA = 2'd2,   // set enable bits (write ones)
      SEL_VEC = 2'd3    // load one vector
   } vic_sel_e;

endpackage

// File: rtl/vic_edge_sync.sv
// Per-source synchroniser followed by a rising-edge detector.
module vic_edge_sync #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] rise_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("vic_edge_sync: STAGES must be at least 1");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic sync_q;
      logic prev_q;

      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= src_i[i];
         end
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], src_i[i]};
         end
         assign sync_q = chain_q[STAGES-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= sync_q;
      end

      assign rise_o[i] = sync_q & ~prev_q;
   end

endmodule

// File: rtl/vic_req_mask.sv
// Sticky request register and enable mask. A set beats a clear on the same bit.
module vic_req_mask #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   input  logic [NUM_SRC-1:0] ena_i,
   input  logic [NUM_SRC-1:0] dis_i,
   output logic [NUM_SRC-1:0] req_o,
   output logic [NUM_SRC-1:0] mask_o
);

   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= '0;
         mask_q <= '0;
      end else begin
         req_q  <= (req_q & ~clr_i) | set_i;
         mask_q <= (mask_q & ~dis_i) | ena_i;
      end
   end

   assign req_o  = req_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/vic_prio_pick.sv
// Picks the lowest-indexed set bit.
module vic_prio_pick #(
   parameter int unsigned NUM_SRC = 16,
   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               vld_o
);

   always_comb begin
      idx_o = '0;
      vld_o = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend_i[i]) begin
            idx_o = IDX_W'(i);
            vld_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/vic_vec_file.sv
// One programmable vector per source. All vectors reset to zero.
module vic_vec_file #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned VEC_W   = 8,
   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [VEC_W-1:0] wr_vec_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [VEC_W-1:0] rd_vec_o
);

   logic [VEC_W-1:0] vec_q [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                                  vec_q[i] <= '0;
         else if (wr_i && (wr_idx_i == IDX_W'(i)))    vec_q[i] <= wr_vec_i;
      end
   end

   always_comb begin
      rd_vec_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (rd_idx_i == IDX_W'(i)) rd_vec_o = vec_q[i];
      end
   end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned WDATA_W     = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   src_i,
   input  logic                 bus_wr_i,
   input  logic [1:0]           bus_sel_i,
   input  logic [WDATA_W-1:0]   bus_wdata_i,
   input  logic                 ack_i,
   output logic                 irq_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic [2*NUM_SRC-1:0] status_o
);
   import vic_pkg::*;

   localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned IDX_LSB = VEC_W;

   // Elaboration checks
   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_src
      $error("vec_irq_ctrl: NUM_SRC out of range");
   end
   if (WDATA_W < NUM_SRC) begin : g_bad_wmask
      $error("vec_irq_ctrl: WDATA_W narrower than NUM_SRC");
   end
   if (WDATA_W < VEC_W + IDX_W) begin : g_bad_wvec
      $error("vec_irq_ctrl: WDATA_W cannot hold vector and index");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("vec_irq_ctrl: SYNC_STAGES must be at least 1");
   end

   // Edge capture
   logic [NUM_SRC-1:0] rise;

   vic_edge_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .rise_o (rise)
   );

   // Write decode
   vic_sel_e           sel;
   logic [NUM_SRC-1:0] wr_bits;
   logic [NUM_SRC-1:0] wr_clr, wr_dis, wr_ena;
   logic               wr_vec;
   logic [IDX_W-1:0]   wr_idx;
   logic [VEC_W-1:0]   wr_val;

   assign sel     = vic_sel_e'(bus_sel_i);
   assign wr_bits = bus_wdata_i[NUM_SRC-1:0];
   assign wr_clr  = (bus_wr_i && sel == SEL_CLR) ? wr_bits : '0;
   assign wr_dis  = (bus_wr_i && sel == SEL_DIS) ? wr_bits : '0;
   assign wr_ena  = (bus_wr_i && sel == SEL_ENA) ? wr_bits : '0;
   assign wr_idx  = bus_wdata_i[IDX_LSB +: IDX_W];
   assign wr_val  = bus_wdata_i[VEC_W-1:0];
   assign wr_vec  = bus_wr_i && (sel == SEL_VEC) && (32'(wr_idx) < NUM_SRC);

   // Acknowledge start detect
   logic ack_q;
   logic ack_start;

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack_i;
   end
   assign ack_start = ack_i & ~ack_q;

   // Requests and mask
   logic [NUM_SRC-1:0] req, mask, pend, ack_clr;
   logic [IDX_W-1:0]   win_idx;
   logic               win_vld;

   vic_req_mask #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (rise),
      .clr_i  (wr_clr | ack_clr),
      .ena_i  (wr_ena),
      .dis_i  (wr_dis),
      .req_o  (req),
      .mask_o (mask)
   );

   assign pend = req & mask;

   vic_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .pend_i (pend),
      .idx_o  (win_idx),
      .vld_o  (win_vld)
   );

   always_comb begin
      ack_clr = '0;
      if (ack_start && win_vld) ack_clr[win_idx] = 1'b1;
   end

   // Vector storage and latch of the served vector
   logic [VEC_W-1:0] win_vec;
   logic [VEC_W-1:0] vec_lat_q;
   logic             lat_vld_q;

   vic_vec_file #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_vecs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_vec),
      .wr_idx_i (wr_idx),
      .wr_vec_i (wr_val),
      .rd_idx_i (win_idx),
      .rd_vec_o (win_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_lat_q <= '0;
         lat_vld_q <= 1'b0;
      end else if (ack_start) begin
         vec_lat_q <= win_vec;
         lat_vld_q <= win_vld;
      end
   end

   // Outputs
   assign vec_o    = (ack_i && ack_q && lat_vld_q) ? vec_lat_q : '0;
   assign irq_o    = |pend;
   assign status_o = {req, pend};

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned VEC_W   = 8,
   parameter int unsigned WDATA_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr_i,
   input logic [1:0]           bus_sel_i,
   input logic [WDATA_W-1:0]   bus_wdata_i,
   input logic                 ack_i,
   input logic                 irq_o,
   input logic [VEC_W-1:0]     vec_o,
   input logic [2*NUM_SRC-1:0] status_o,
   input logic [NUM_SRC-1:0]   rise,
   input logic                 ack_q,
   input logic                 ack_start
);

   logic [NUM_SRC-1:0] raw, gated, wbits;
   assign raw   = status_o[2*NUM_SRC-1:NUM_SRC];
   assign gated = status_o[NUM_SRC-1:0];
   assign wbits = bus_wdata_i[NUM_SRC-1:0];

   // R6: the line follows the gated half of the status word
   a_r6_irq_follows_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (|gated));

   // R10: gated requests are always a subset of raw requests
   a_r10_gated_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (gated & ~raw) == '0);

   // R2: written ones clear unless an edge arrives on the same bit
   a_r2_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_sel_i == 2'd0) |=> ((raw & $past(wbits & ~rise)) == '0));

   // R5: mask writes leave requests untouched
   a_r5_mask_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && (bus_sel_i == 2'd1 || bus_sel_i == 2'd2) && rise == '0 && !ack_start)
      |=> (raw == $past(raw)));

   // R12: a captured edge always leaves its bit set
   a_r12_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((raw & $past(rise)) == $past(rise)));

   // R9: no vector outside an acknowledge
   a_r9_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |-> (vec_o == '0));

   // R9: an acknowledge clears at most one request
   a_r9_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_start && !bus_wr_i) |=> ($countones($past(raw) & ~raw) <= 1));

   // R11: the vector holds steady through one acknowledge
   a_r11_vec_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_q && $past(ack_i && ack_q)) |-> $stable(vec_o));

endmodule

bind vec_irq_ctrl vic_checker #(
   .NUM_SRC (NUM_SRC),
   .VEC_W   (VEC_W),
   .WDATA_W (WDATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_i    (bus_wr_i),
   .bus_sel_i   (bus_sel_i),
   .bus_wdata_i (bus_wdata_i),
   .ack_i       (ack_i),
   .irq_o       (irq_o),
   .vec_o       (vec_o),
   .status_o    (status_o),
   .rise        (rise),
   .ack_q       (ack_q),
   .ack_start   (ack_start)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;

   localparam int unsigned NS = 16;
   localparam int unsigned VW = 8;
   localparam int unsigned WW = 16;
   localparam int unsigned SS = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] src;
   logic          wr;
   logic [1:0]    sel;
   logic [WW-1:0] wdata;
   logic          ack;
   logic          irq;
   logic [VW-1:0] vec;
   logic [2*NS-1:0] status;

   always #2 clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(NS), .VEC_W(VW), .WDATA_W(WW), .SYNC_STAGES(SS)) u_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_sel_i(sel),
      .bus_wdata_i(wdata), .ack_i(ack), .irq_o(irq), .vec_o(vec), .status_o(status)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [NS-1:0] m_req, m_mask;
   logic [VW-1:0] m_vec [NS];

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic chk_state(input string r);
      chk({r, " status"}, 32'(status), 32'({m_req, m_req & m_mask}));
      chk({r, " irq"}, 32'(irq), 32'(|(m_req & m_mask)));
   endtask

   function automatic int lowest(input logic [NS-1:0] v);
      for (int i = 0; i < NS; i++) if (v[i]) return i;
      return -1;
   endfunction

   // sel: 0 clear, 1 disable, 2 enable, 3 vector
   task automatic bus_write(input logic [1:0] s, input logic [WW-1:0] d);
      @(negedge clk);
      wr = 1'b1; sel = s; wdata = d;
      @(negedge clk);
      wr = 1'b0;
      case (s)
         2'd0: m_req  = m_req & ~d[NS-1:0];
         2'd1: m_mask = m_mask & ~d[NS-1:0];
         2'd2: m_mask = m_mask | d[NS-1:0];
         default: m_vec[d[11:8]] = d[7:0];
      endcase
   endtask

   task automatic pulse(input logic [NS-1:0] bits);
      @(negedge clk);
      src = src | bits;
      repeat (SS + 3) @(negedge clk);
      src = src & ~bits;
      repeat (SS + 2) @(negedge clk);
      m_req = m_req | bits;
   endtask

   task automatic do_ack(input string r);
      int w;
      logic [VW-1:0] e;
      w = lowest(m_req & m_mask);
      e = (w >= 0) ? m_vec[w] : '0;
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      chk({r, " vec"}, 32'(vec), 32'(e));
      ack = 1'b0;
      if (w >= 0) m_req[w] = 1'b0;
      @(negedge clk);
      chk({r, " vec after"}, 32'(vec), 32'h0);
      chk_state(r);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd1234);
      rst_n = 1'b0; src = '0; wr = 1'b0; sel = '0; wdata = '0; ack = 1'b0;
      m_req = '0; m_mask = '0;
      for (int i = 0; i < NS; i++) m_vec[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 reset state
      chk("R4 reset status", 32'(status), 32'h0);
      chk("R4 reset irq", 32'(irq), 32'h0);
      chk("R4 reset vec", 32'(vec), 32'h0);

      // R5: captured while masked, then enabled
      pulse(16'h0010);
      chk_state("R5 masked capture");
      bus_write(2'd2, 16'h0010);
      chk_state("R5 enable raises irq");
      // R7: vectors reset to zero
      do_ack("R7 zero vector after reset");

      // R7: program all vectors
      for (int i = 0; i < NS; i++) bus_write(2'd3, WW'((i << 8) | (8'h40 + i * 3)));
      bus_write(2'd2, 16'hFFFF);
      chk_state("R3 enable all");

      // R8: priority among several pending
      pulse(16'h8420);
      chk_state("R10 status layout");
      do_ack("R8 lowest first (5)");
      do_ack("R8 next (10)");
      do_ack("R8 next (15)");
      do_ack("R9 empty ack");

      // R3 / R5: disable keeps requests
      pulse(16'h0003);
      bus_write(2'd1, 16'h0001);
      chk_state("R3 disable bit0");
      do_ack("R3 masked bit skipped");
      bus_write(2'd2, 16'h0001);
      do_ack("R5 re-enabled bit served");

      // R1: a held level does not set the request again
      @(negedge clk);
      src[2] = 1'b1;
      repeat (SS + 3) @(negedge clk);
      m_req[2] = 1'b1;
      chk_state("R1 edge captured");
      bus_write(2'd0, 16'h0004);
      repeat (6) @(negedge clk);
      chk_state("R1 held level ignored");
      src[2] = 1'b0;
      repeat (SS + 2) @(negedge clk);

      // R12: edge and clear on the same cycle
      @(negedge clk);
      src[3] = 1'b1;
      repeat (SS) @(negedge clk);
      wr = 1'b1; sel = 2'd0; wdata = 16'h0008;
      @(negedge clk);
      wr = 1'b0;
      m_req[3] = 1'b1;
      chk_state("R12 edge beats clear");
      src[3] = 1'b0;
      repeat (SS + 2) @(negedge clk);
      do_ack("R12 served");

      // R11: new edge and vector rewrite during an acknowledge
      pulse(16'h0020);
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      src[0] = 1'b1;
      wr = 1'b1; sel = 2'd3; wdata = 16'h05AA;
      @(negedge clk);
      wr = 1'b0;
      repeat (SS + 3) @(negedge clk);
      chk("R11 vector held", 32'(vec), 32'(m_vec[5]));
      ack = 1'b0;
      m_vec[5] = 8'hAA;
      m_req[5] = 1'b0;
      m_req[0] = 1'b1;
      @(negedge clk);
      chk_state("R11 only winner cleared");
      src[0] = 1'b0;
      repeat (SS + 2) @(negedge clk);
      do_ack("R11 new edge served later");

      // Random mix
      for (int n = 0; n < 300; n++) begin
         int op;
         op = int'($urandom % 6);
         case (op)
            0: pulse(NS'($urandom) & NS'($urandom));
            1: bus_write(2'd0, WW'($urandom));
            2: bus_write(2'd1, WW'($urandom) & WW'($urandom));
            3: bus_write(2'd2, WW'($urandom));
            4: bus_write(2'd3, WW'($urandom) & 16'h0FFF);
            default: do_ack("R9 random ack");
         endcase
         chk_state("R2 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule